// File: doc/BRIEF.md
# Static-Route Packet Switch with Per-Pair Queues

This block forwards fixed-size 40-bit packets between a set of ports. Each arriving packet carries a 12-bit destination key in its top bits. That key is looked up in a route table, and the table names the output port. The table is loaded while the switch is held in a configuration state. No route is computed while traffic flows, so the path a packet takes and the number of cycles it spends in the switch are known in advance.

Every input/output pair has its own small FIFO. A packet that waits for a busy output therefore only holds up later traffic of the same pair. Each output has a round-robin arbiter that picks one non-empty pair queue per cycle and sends that packet out through a registered crossbar stage. A packet whose key has no usable table entry is accepted and discarded, and a miss counter records it.

Top module: `static_route_switch`

## Requirements
- R1: After reset every `out_valid` bit is 0 and `miss_count` is 0. All table entries are invalid, and no queue holds a packet.
- R2: The lookup key is packet bits [39:28]. The table slot is the low log2(TBL_DEPTH) bits of the key. A table entry is 16 bits: bit 15 is valid, bits [14:3] hold the full key, and bits [2:0] hold the output port. An accepted packet whose slot is valid, whose stored key equals its own key, and whose port field is below NPORT leaves unchanged on that output port.
- R3: A packet is counted as a miss when its slot is invalid, when the stored key differs from its key, or when its port field is NPORT or above. A missed packet is accepted, produces no output, and adds one to `miss_count`. Misses on several inputs in the same cycle all count.
- R4: Packets from one input to one output leave in the order they arrived. No accepted packet that hits the table is lost.
- R5: `in_ready` of an input is low while the pair queue its packet targets is full. A full queue is never written.
- R6: Each output grants its non-empty pair queues in round-robin order over the input index. While several queues stay non-empty, successive grants rotate through them.
- R7: Latency is fixed. A packet accepted at clock edge A into an empty queue, with no other traffic for its output, shows on `out_valid`/`out_data` after edge A+1.
- R8: While `cfg_mode` is 1, every `in_ready` bit is 0, no output is produced, and `miss_count` holds. Table writes (`cfg_we`) take effect only while `cfg_mode` is 1. A write made with `cfg_mode` at 0 is ignored.
- R9: An output with queued traffic sends one packet on every cycle until its queues are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 1 | 1 = configuration state: forwarding stops, table writes are allowed |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | log2(TBL_DEPTH) | Table slot to write |
| cfg_entry | input | 16 | Entry: valid[15], key[14:3], port[2:0] |
| in_valid | input | NPORT | Packet present, one bit per input |
| in_data | input | NPORT*40 | Packets; input i uses bits [40*i+39:40*i] |
| in_ready | output | NPORT | Input i accepts its packet at this edge |
| out_valid | output | NPORT | Output packet valid, one bit per output |
| out_data | output | NPORT*40 | Output packets, laid out as in_data |
| miss_count | output | CNT_W | Number of packets dropped on a lookup miss |

## Verification
The bound checker checks the following on every cycle:
- no pair queue is pushed while it is full;
- each output grants at most one queue;
- configuration mode blocks intake, output and miss counting;
- reset clears the outputs.

Other properties need whole scenarios and are checked by the bench:
- the table's hit and miss decisions, including mismatched keys, bad port numbers and writes ignored outside configuration mode;
- per-pair ordering and that no packet is lost under back-pressure;
- the exact rotation of grants;
- the fixed two-edge latency and the sustained rate of one packet per cycle.

// File: rtl/sw_pkg.sv
package sw_pkg;
  localparam int PKT_W    = 40;
  localparam int KEY_W    = 12;
  localparam int ENTRY_W  = 16;
  localparam int PFLD_W   = 3;
  localparam int KEY_LSB  = PKT_W - KEY_W;

  function automatic logic entry_valid(input logic [ENTRY_W-1:0] e);
    return e[ENTRY_W-1];
  endfunction

  function automatic logic [KEY_W-1:0] entry_key(input logic [ENTRY_W-1:0] e);
    return e[PFLD_W +: KEY_W];
  endfunction

  function automatic logic [PFLD_W-1:0] entry_port(input logic [ENTRY_W-1:0] e);
    return e[PFLD_W-1:0];
  endfunction
endpackage

// File: rtl/sw_route_table.sv
module sw_route_table
  import sw_pkg::*;
#(
  parameter int NPORT     = 4,
  parameter int TBL_DEPTH = 16,
  localparam int IDX_W    = $clog2(TBL_DEPTH),
  localparam int PORT_W   = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [IDX_W-1:0]        widx,
  input  logic [ENTRY_W-1:0]      wentry,
  input  logic [NPORT*KEY_W-1:0]  key,
  output logic [NPORT-1:0]        hit,
  output logic [NPORT*PORT_W-1:0] port
);
  localparam int BODY_W = KEY_W + PFLD_W;

  logic [BODY_W-1:0]    body_mem [TBL_DEPTH];
  logic [TBL_DEPTH-1:0] valid_q;

  always_ff @(posedge clk) begin
    if (we) body_mem[widx] <= wentry[BODY_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)     valid_q <= '0;
    else if (we) valid_q[widx] <= entry_valid(wentry);
  end

  for (genvar i = 0; i < NPORT; i++) begin : g_look
    logic [KEY_W-1:0]  k;
    logic [IDX_W-1:0]  slot;
    logic [BODY_W-1:0] body;
    logic [ENTRY_W-1:0] ent;
    assign k    = key[i*KEY_W +: KEY_W];
    assign slot = k[IDX_W-1:0];
    assign body = body_mem[slot];
    assign ent  = {valid_q[slot], body};
    assign hit[i] = entry_valid(ent) && (entry_key(ent) == k) &&
                    (int'(entry_port(ent)) < NPORT);
    assign port[i*PORT_W +: PORT_W] = PORT_W'(entry_port(ent));
  end
endmodule

// File: rtl/sw_pair_fifo.sv
module sw_pair_fifo #(
  parameter int W     = 40,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [AW:0]   cnt_q;

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= (int'(wr_q) == DEPTH-1) ? '0 : wr_q + 1'b1;
      if (pop)  rd_q <= (int'(rd_q) == DEPTH-1) ? '0 : rd_q + 1'b1;
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign dout  = mem[rd_q];
  assign empty = (cnt_q == '0);
  assign full  = (int'(cnt_q) == DEPTH);
endmodule

// File: rtl/sw_rr_arb.sv
module sw_rr_arb #(
  parameter int N   = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  logic [IW-1:0] last_q;
  logic [IW-1:0] win;
  logic          found;

  always_comb begin
    grant = '0;
    win   = last_q;
    found = 1'b0;
    for (int off = 1; off <= N; off++) begin
      int idx;
      idx = (int'(last_q) + off) % N;
      if (!found && req[idx]) begin
        found      = 1'b1;
        grant[idx] = 1'b1;
        win        = IW'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        last_q <= IW'(N-1);
    else if (found) last_q <= win;
  end
endmodule

// File: rtl/static_route_switch.sv
module static_route_switch
  import sw_pkg::*;
#(
  parameter int NPORT      = 4,
  parameter int TBL_DEPTH  = 16,
  parameter int FIFO_DEPTH = 4,
  parameter int CNT_W      = 16,
  localparam int IDX_W     = $clog2(TBL_DEPTH),
  localparam int PORT_W    = (NPORT > 1) ? $clog2(NPORT) : 1,
  localparam int NQ        = NPORT * NPORT
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_mode,
  input  logic                   cfg_we,
  input  logic [IDX_W-1:0]       cfg_idx,
  input  logic [ENTRY_W-1:0]     cfg_entry,
  input  logic [NPORT-1:0]       in_valid,
  input  logic [NPORT*PKT_W-1:0] in_data,
  output logic [NPORT-1:0]       in_ready,
  output logic [NPORT-1:0]       out_valid,
  output logic [NPORT*PKT_W-1:0] out_data,
  output logic [CNT_W-1:0]       miss_count
);
  logic [NPORT*KEY_W-1:0]  keys;
  logic [NPORT-1:0]        hit;
  logic [NPORT*PORT_W-1:0] dst;
  logic [NPORT-1:0]        miss_pulse;
  logic [NQ-1:0]           fifo_push, fifo_pop, fifo_empty, fifo_full;
  logic [NQ*PKT_W-1:0]     fifo_dout;
  logic [NQ-1:0]           grant_flat;
  logic                    run;

  assign run = !cfg_mode;

  for (genvar i = 0; i < NPORT; i++) begin : g_key
    assign keys[i*KEY_W +: KEY_W] = in_data[i*PKT_W + KEY_LSB +: KEY_W];
  end

  sw_route_table #(.NPORT(NPORT), .TBL_DEPTH(TBL_DEPTH)) u_table (
    .clk(clk), .rst(rst), .we(cfg_we && cfg_mode), .widx(cfg_idx),
    .wentry(cfg_entry), .key(keys), .hit(hit), .port(dst)
  );

  for (genvar i = 0; i < NPORT; i++) begin : g_in
    logic [PORT_W-1:0] p;
    logic              tgt_full;
    assign p        = dst[i*PORT_W +: PORT_W];
    assign tgt_full = fifo_full[i*NPORT + int'(p)];
    assign in_ready[i]   = run && (!hit[i] || !tgt_full);
    assign miss_pulse[i] = in_valid[i] && in_ready[i] && !hit[i];
    for (genvar j = 0; j < NPORT; j++) begin : g_pair
      assign fifo_push[i*NPORT+j] = in_valid[i] && in_ready[i] && hit[i] &&
                                    (int'(p) == j);
      sw_pair_fifo #(.W(PKT_W), .DEPTH(FIFO_DEPTH)) u_q (
        .clk(clk), .rst(rst),
        .push(fifo_push[i*NPORT+j]), .din(in_data[i*PKT_W +: PKT_W]),
        .pop(fifo_pop[i*NPORT+j]), .dout(fifo_dout[(i*NPORT+j)*PKT_W +: PKT_W]),
        .empty(fifo_empty[i*NPORT+j]), .full(fifo_full[i*NPORT+j])
      );
    end
  end

  for (genvar j = 0; j < NPORT; j++) begin : g_out
    logic [NPORT-1:0] req, gnt;
    logic [PKT_W-1:0] sel;
    for (genvar i = 0; i < NPORT; i++) begin : g_req
      assign req[i] = run && !fifo_empty[i*NPORT+j];
      assign fifo_pop[i*NPORT+j] = gnt[i];
      assign grant_flat[j*NPORT+i] = gnt[i];
    end

    sw_rr_arb #(.N(NPORT)) u_arb (
      .clk(clk), .rst(rst), .req(req), .grant(gnt)
    );

    always_comb begin
      sel = '0;
      for (int i = 0; i < NPORT; i++)
        if (gnt[i]) sel = sel | fifo_dout[(i*NPORT+j)*PKT_W +: PKT_W];
    end

    always_ff @(posedge clk) begin
      if (rst) out_valid[j] <= 1'b0;
      else     out_valid[j] <= |gnt;
    end

    always_ff @(posedge clk) begin
      if (|gnt) out_data[j*PKT_W +: PKT_W] <= sel;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) miss_count <= '0;
    else     miss_count <= miss_count + CNT_W'($countones(miss_pulse));
  end
endmodule

// File: rtl/sw_checker.sv
module sw_checker #(
  parameter int NPORT = 4,
  parameter int CNT_W = 16,
  localparam int NQ   = NPORT * NPORT
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_mode,
  input logic [NPORT-1:0] in_ready,
  input logic [NPORT-1:0] out_valid,
  input logic [CNT_W-1:0] miss_count,
  input logic [NQ-1:0]    fifo_full,
  input logic [NQ-1:0]    fifo_push,
  input logic [NQ-1:0]    grant_flat
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (out_valid == '0 && miss_count == '0));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    (fifo_push & fifo_full) == '0);

  for (genvar j = 0; j < NPORT; j++) begin : g_gnt
    assert_one_grant_R6: assert property (@(posedge clk) disable iff (rst)
      $onehot0(grant_flat[j*NPORT +: NPORT]));
  end

  assert_cfg_no_intake_R8: assert property (@(posedge clk) disable iff (rst)
    cfg_mode |-> in_ready == '0);

  assert_cfg_no_output_R8: assert property (@(posedge clk) disable iff (rst)
    cfg_mode |=> out_valid == '0);

  assert_cfg_miss_hold_R8: assert property (@(posedge clk) disable iff (rst)
    cfg_mode |=> $stable(miss_count));
endmodule

bind static_route_switch sw_checker #(.NPORT(NPORT), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .in_ready(in_ready),
  .out_valid(out_valid), .miss_count(miss_count), .fifo_full(fifo_full),
  .fifo_push(fifo_push), .grant_flat(grant_flat)
);

// File: tb/static_route_switch_bench.sv
module static_route_switch_bench;
  localparam int N  = 4;
  localparam int PW = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_mode = 1'b0, cfg_we = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic [15:0] cfg_entry = '0;
  logic [N-1:0] drv_valid = '0;
  logic [PW-1:0] drv_data [N];
  logic [N*PW-1:0] in_data;
  logic [N-1:0] in_ready, out_valid;
  logic [N*PW-1:0] out_data;
  logic [15:0] miss_count;

  always #2 clk = ~clk;

  always_comb
    for (int i = 0; i < N; i++) in_data[i*PW +: PW] = drv_data[i];

  static_route_switch u_static_route_switch (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_we(cfg_we),
    .cfg_idx(cfg_idx), .cfg_entry(cfg_entry), .in_valid(drv_valid),
    .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid),
    .out_data(out_data), .miss_count(miss_count)
  );

  int checks = 0, errors = 0;
  int exp_miss = 0;
  logic [PW-1:0] expq [N*N][$];
  logic        m_valid [16];
  logic [11:0] m_key   [16];
  logic [2:0]  m_port  [16];
  bit saw_stall = 0;
  bit rec_en = 0;
  int rec_src [$];
  int run_len = 0, max_run = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tbl_write(input int idx, input bit v, input logic [11:0] k, input logic [2:0] p);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_entry = {v, k, p};
    if (cfg_mode) begin
      m_valid[idx] = v; m_key[idx] = k; m_port[idx] = p;
    end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(input int p, input logic [11:0] addr, input int tag);
    logic [PW-1:0] pkt;
    int slot;
    bit h;
    pkt  = {addr, 24'(tag), 4'(p)};
    slot = int'(addr[3:0]);
    h    = m_valid[slot] && m_key[slot] == addr && int'(m_port[slot]) < N;
    @(negedge clk);
    drv_valid[p] = 1'b1; drv_data[p] = pkt;
    forever begin
      #1;
      if (in_ready[p]) begin
        @(posedge clk);
        if (h) expq[p*N + int'(m_port[slot])].push_back(pkt);
        else   exp_miss++;
        break;
      end
      saw_stall = 1;
      @(negedge clk);
    end
  endtask

  task automatic release_port(input int p);
    @(negedge clk);
    drv_valid[p] = 1'b0;
  endtask

  // monitor: pops the scoreboard as packets leave
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        for (int j = 0; j < N; j++) begin
          if (out_valid[j]) begin
            logic [PW-1:0] got;
            int src;
            got = out_data[j*PW +: PW];
            src = int'(got[3:0]);
            if (src >= N || expq[src*N+j].size() == 0) begin
              check(0, "R2/R4 unexpected packet", longint'(got), 0);
            end else begin
              logic [PW-1:0] e;
              e = expq[src*N+j].pop_front();
              check(got == e, "R4 pair order/data", longint'(got), longint'(e));
            end
            if (rec_en && j == 1) rec_src.push_back(src);
          end
        end
        if (rec_en && out_valid[1]) begin
          run_len++;
          if (run_len > max_run) max_run = run_len;
        end else run_len = 0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      m_valid[i] = 0; m_key[i] = '0; m_port[i] = '0;
    end
    for (int i = 0; i < N; i++) drv_data[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    // R1
    check(out_valid == '0, "R1 out_valid after reset", longint'(out_valid), 0);
    check(miss_count == 0, "R1 miss_count after reset", longint'(miss_count), 0);

    // table load in configuration state
    cfg_mode = 1'b1;
    tbl_write(3,  1, 12'h123, 3'd2);
    tbl_write(5,  1, 12'h045, 3'd0);
    tbl_write(7,  1, 12'h2A7, 3'd1);
    tbl_write(12, 1, 12'h30C, 3'd3);
    tbl_write(9,  1, 12'h019, 3'd6);
    tbl_write(14, 0, 12'h04E, 3'd1);
    // R8: intake blocked in configuration state
    @(negedge clk);
    drv_valid[0] = 1'b1; drv_data[0] = {12'h123, 24'h0, 4'd0};
    #1;
    check(in_ready == '0, "R8 in_ready in cfg mode", longint'(in_ready), 0);
    repeat (3) @(negedge clk);
    check(out_valid == '0, "R8 no output in cfg mode", longint'(out_valid), 0);
    check(miss_count == 0, "R8 miss held in cfg mode", longint'(miss_count), 0);
    drv_valid[0] = 1'b0;
    cfg_mode = 1'b0;
    // R8: write outside configuration state is ignored
    tbl_write(10, 1, 12'h0AA, 3'd1);

    // R7 + R2: single packet latency
    send(0, 12'h123, 1);
    release_port(0);
    check(out_valid[2] == 1'b0, "R7 not early", longint'(out_valid), 0);
    @(negedge clk);
    check(out_valid == 4'b0100, "R7 R2 out port and latency", longint'(out_valid), 4);
    check(out_data[2*PW +: PW] == {12'h123, 24'd1, 4'd0}, "R2 data intact",
          longint'(out_data[2*PW +: PW]), longint'({12'h123, 24'd1, 4'd0}));

    // R3: misses of every kind, plus R8 ignored write
    send(1, 12'h0AA, 2);
    send(1, 12'h019, 3);
    send(1, 12'h04E, 4);
    send(1, 12'h523, 5);
    release_port(1);
    repeat (3) @(negedge clk);
    check(miss_count == 16'(exp_miss) && exp_miss == 4, "R3 R8 miss count",
          longint'(miss_count), 4);
    // R3: simultaneous misses on several inputs
    fork
      begin send(0, 12'h0AA, 6); release_port(0); end
      begin send(2, 12'h04E, 7); release_port(2); end
    join
    repeat (2) @(negedge clk);
    check(miss_count == 16'd6, "R3 concurrent misses", longint'(miss_count), 6);

    // R4: ordered burst on one pair
    for (int k = 0; k < 5; k++) send(1, 12'h045, 10 + k);
    release_port(1);
    repeat (4) @(negedge clk);
    check(expq[1*N+0].size() == 0, "R4 burst delivered", expq[4].size(), 0);

    // R6 + R9: three inputs contend for output 1
    rec_en = 1;
    fork
      begin for (int k = 0; k < 3; k++) send(0, 12'h2A7, 20 + k); release_port(0); end
      begin for (int k = 0; k < 3; k++) send(1, 12'h2A7, 30 + k); release_port(1); end
      begin for (int k = 0; k < 3; k++) send(2, 12'h2A7, 40 + k); release_port(2); end
    join
    repeat (12) @(negedge clk);
    rec_en = 0;
    check(rec_src.size() == 9, "R6 grant count", rec_src.size(), 9);
    for (int k = 0; k + 1 < rec_src.size(); k++)
      check(rec_src[k+1] == (rec_src[k] + 1) % 3, "R6 round-robin rotation",
            rec_src[k+1], (rec_src[k] + 1) % 3);
    check(max_run == 9, "R9 one packet per cycle", max_run, 9);

    // R5: all inputs to output 3 until queues fill
    fork
      begin for (int k = 0; k < 8; k++) send(0, 12'h30C, 50 + k); release_port(0); end
      begin for (int k = 0; k < 8; k++) send(1, 12'h30C, 60 + k); release_port(1); end
      begin for (int k = 0; k < 8; k++) send(2, 12'h30C, 70 + k); release_port(2); end
      begin for (int k = 0; k < 8; k++) send(3, 12'h30C, 80 + k); release_port(3); end
    join
    repeat (40) @(negedge clk);
    check(saw_stall, "R5 back-pressure seen", longint'(saw_stall), 1);
    for (int q = 0; q < N*N; q++)
      check(expq[q].size() == 0, "R4 R5 nothing lost", expq[q].size(), 0);
    check(miss_count == 16'd6, "R3 final miss count", longint'(miss_count), 6);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule